// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Frame Interface

This block is the digital side of a six-channel converter that samples every channel at the same instant. A rising edge on the conversion-start input captures one 14-bit word per selected channel. The captured words are then delivered over a serial data line. An external serial clock times the line, and each channel takes one 16-clock slot, so a full frame is 96 clocks long. The output is pipelined. A frame always carries the words captured by the conversion before it. The new words move into the readable result registers only when the frame closes, so the data never changes while it is being shifted out.

The conversion-start and serial-clock pins are asynchronous to the system clock. Each passes through a two-flop synchronizer before its edges are detected. A watchdog counter runs on the system clock. It flags a serial clock that starts too late after a conversion, or that pauses too long inside a frame. The caller can select fewer than six channels. Result registers of channels that are not selected keep their old contents, and their slots still go out with that stale data.

Top module: `sadc_frame_top`

## Requirements
- R1: An accepted conversion captures `sample_i` for all selected channels in one system-clock cycle (channel c on bits [14c+13:14c]). Later changes to `sample_i` do not alter the captured words.
- R2: A conversion-start rising edge that arrives while `busy_o` is high is ignored. It neither restarts the frame nor captures new words.
- R3: `busy_o` rises when a conversion-start edge is accepted and falls at the 96th serial-clock rising edge after it.
- R4: A frame sends six 16-bit slots in ascending channel order from channel 0. Each slot holds the 14-bit word MSB first, followed by two zero bits. Bit 0 is on `sdo_o` once the frame starts. Each later bit appears after a serial-clock falling edge, ready for the next rising edge.
- R5: A frame shifts out the words of the previous accepted conversion. The result registers change only when a frame closes.
- R6: `chan_cnt_i` = n with 1 <= n <= 6 captures channels 0..n-1 only. The other channels keep their old words. The values 0 and 7 mean all six channels.
- R7: `tviol_o` goes high if no serial-clock rising edge arrives within TIMEOUT_CYC system clocks after an accepted conversion.
- R8: `tviol_o` goes high if the gap between two serial-clock rising edges inside a frame exceeds TIMEOUT_CYC system clocks. It stays high until the next accepted conversion, which clears it.
- R9: After reset, all result registers hold zero, and `busy_o`, `sdo_o` and `tviol_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_i | input | 1 | Conversion start, asynchronous, rising edge |
| sck_i | input | 1 | External serial clock, asynchronous |
| chan_cnt_i | input | 3 | Number of channels to convert |
| sample_i | input | 84 | Six parallel 14-bit sample words |
| sdo_o | output | 1 | Serial data out |
| busy_o | output | 1 | Frame in progress |
| tviol_o | output | 1 | Serial-clock timing violation, sticky |

## Verification
The first frame after reset must read all zeros. A second full frame with distinct per-channel words then separates correct slot ordering, MSB-first bit order and the trailing zero bits from shifted or swapped data. A three-channel conversion followed by a frame that reads all six shows whether unselected registers stay stale. Scrambling `sample_i` right after acceptance shows whether capture happens at one instant. A conversion pulse in the middle of a frame, with new sample words on the inputs, shows whether the lockout holds. A late first clock and a stall in the middle of a frame each have to raise the violation flag, and clean frames must leave it low.

// File: rtl/sadc_pkg.sv
// Shared constants and types for the simultaneous-sampling frame interface.
// Assumes a fixed slot width of 16 with a 14-bit result left-aligned.
package sadc_pkg;
    localparam int NUM_CH     = 6;
    localparam int RES_W      = 14;
    localparam int SLOT_W     = 16;
    localparam int FRAME_BITS = NUM_CH * SLOT_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int SEL_W      = $clog2(NUM_CH + 1);

    typedef logic [RES_W-1:0] res_t;
endpackage

// File: rtl/sadc_sync.sv
// Two-flop synchronizer for W independent asynchronous single-bit inputs.
// Assumes each bit is a level that stays put for several system clocks.
module sadc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    // Two-stage capture into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/sadc_frame_ctrl.sv
// Frame sequencer: accepts a conversion edge when idle, counts serial-clock
// rising edges, and closes the frame at the last bit of the frame.
// Assumes edge strobes are one system clock wide.
module sadc_frame_ctrl
    import sadc_pkg::*;
#(
    parameter int NBITS = FRAME_BITS,
    localparam int CW   = $clog2(NBITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_rise_i,
    input  logic          sck_rise_i,
    output logic          busy_o,
    output logic          accept_o,
    output logic          done_o,
    output logic [CW-1:0] bit_cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

    assign accept_o = conv_rise_i && !busy_o;
    assign done_o   = busy_o && sck_rise_i && (bit_cnt_o == LAST);

    // Busy flag and bit counter for the active frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            bit_cnt_o <= '0;
        end else if (accept_o) begin
            busy_o    <= 1'b1;
            bit_cnt_o <= '0;
        end else if (done_o) begin
            busy_o    <= 1'b0;
            bit_cnt_o <= '0;
        end else if (busy_o && sck_rise_i) begin
            bit_cnt_o <= bit_cnt_o + 1'b1;
        end
    end

    AST_BUSY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);                         // R2
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_o <= LAST);                                      // R3
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (bit_cnt_o == '0));                          // R3
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);                                     // R3
endmodule

// File: rtl/sadc_result_bank.sv
// Per-channel capture and result registers. Selected channels are captured
// into a pending stage at accept, and the pending stage moves to the readable
// results at frame close. Assumes accept and commit never coincide.
module sadc_result_bank
    import sadc_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int RW  = RES_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept_i,
    input  logic                   commit_i,
    input  logic [NCH-1:0]         sel_i,
    input  logic [NCH*RW-1:0]      sample_i,
    output logic [NCH-1:0][RW-1:0] res_o
);
    logic [NCH-1:0][RW-1:0] pend_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Capture this channel's sample when selected at accept.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[c] <= '0;
            else if (accept_i && sel_i[c])
                pend_q[c] <= sample_i[c*RW +: RW];
        end

        // Publish the pending word at frame close.
        always_ff @(posedge clk) begin
            if (!rst_n)
                res_o[c] <= '0;
            else if (commit_i)
                res_o[c] <= pend_q[c];
        end
    end

    AST_RES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(res_o));                           // R5
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(pend_q));                          // R1
endmodule

// File: rtl/sadc_gap_timer.sv
// Watchdog on serial-clock activity. It counts system clocks since the
// accept or the last serial-clock rise while a frame is open, and sets a
// sticky flag at the limit. Assumes TIMEOUT_CYC >= 1.
module sadc_gap_timer #(
    parameter int TIMEOUT_CYC = 1000,
    localparam int GW         = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic accept_i,
    input  logic sck_rise_i,
    output logic tviol_o
);
    localparam logic [GW-1:0] LIMIT = GW'(TIMEOUT_CYC);
    logic [GW-1:0] gap_q;

    // Gap counter, restarted by accept and by each serial-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (accept_i || sck_rise_i)
            gap_q <= '0;
        else if (busy_i && gap_q != LIMIT)
            gap_q <= gap_q + 1'b1;
    end

    // Sticky violation flag, cleared by the next accepted conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tviol_o <= 1'b0;
        else if (accept_i)
            tviol_o <= 1'b0;
        else if (busy_i && !sck_rise_i && gap_q == LIMIT)
            tviol_o <= 1'b1;
    end

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> !tviol_o);                                  // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tviol_o && !accept_i) |=> tviol_o);                     // R8
    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= LIMIT);                                         // R7
endmodule

// File: rtl/sadc_frame_top.sv
// Top of the frame interface: synchronizes the pins, detects edges, decodes
// the channel count, drives the serial bit stream from the result registers
// and hosts the timing watchdog.
// Assumes chan_cnt_i and sample_i are stable around the conversion edge.
module sadc_frame_top
    import sadc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    conv_i,
    input  logic                    sck_i,
    input  logic [SEL_W-1:0]        chan_cnt_i,
    input  logic [NUM_CH*RES_W-1:0] sample_i,
    output logic                    sdo_o,
    output logic                    busy_o,
    output logic                    tviol_o
);
    logic [1:0] sync_w;
    logic       conv_d, sck_d;
    logic       conv_rise, sck_rise, sck_fall;
    logic       accept, done;
    logic [CNT_W-1:0] bit_cnt;
    logic [NUM_CH-1:0] sel;
    logic [NUM_CH-1:0][RES_W-1:0] res;
    logic       next_bit;

    sadc_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sck_i, conv_i}),
        .sync_o  (sync_w)
    );

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_d <= 1'b0;
            sck_d  <= 1'b0;
        end else begin
            conv_d <= sync_w[0];
            sck_d  <= sync_w[1];
        end
    end

    assign conv_rise = sync_w[0] && !conv_d;
    assign sck_rise  = sync_w[1] && !sck_d;
    assign sck_fall  = !sync_w[1] && sck_d;

    // Channel-select mask from the requested count; 0 and above NUM_CH mean all.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        assign sel[c] = (chan_cnt_i == '0) || (chan_cnt_i > SEL_W'(NUM_CH)) ||
                        (SEL_W'(c) < chan_cnt_i);
    end

    sadc_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_rise_i (conv_rise),
        .sck_rise_i  (sck_rise),
        .busy_o      (busy_o),
        .accept_o    (accept),
        .done_o      (done),
        .bit_cnt_o   (bit_cnt)
    );

    sadc_result_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .commit_i (done),
        .sel_i    (sel),
        .sample_i (sample_i),
        .res_o    (res)
    );

    sadc_gap_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_o),
        .accept_i   (accept),
        .sck_rise_i (sck_rise),
        .tviol_o    (tviol_o)
    );

    // Pick the frame bit at the current count: slot word MSB first, then zero pad.
    always_comb begin
        res_t word;
        int   slot;
        int   pos;
        word     = '0;
        next_bit = 1'b0;
        slot     = int'(bit_cnt) / SLOT_W;
        pos      = int'(bit_cnt) % SLOT_W;
        for (int c = 0; c < NUM_CH; c++)
            if (slot == c) word = res[c];
        for (int p = 0; p < RES_W; p++)
            if (pos == p) next_bit = word[RES_W-1-p];
    end

    // Output bit register: load at accept, advance on falling edges, clear at close.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sdo_o <= 1'b0;
        else if (accept)
            sdo_o <= next_bit;
        else if (done)
            sdo_o <= 1'b0;
        else if (busy_o && sck_fall)
            sdo_o <= next_bit;
    end

    AST_SDO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !accept) |=> !sdo_o);                        // R4
    AST_SDO_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !sck_fall && !done) |=> $stable(sdo_o));      // R4
endmodule

// File: tb/sadc_frame_top_tb_top.sv
// Directed bench for the frame interface; one task per scenario.
module sadc_frame_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int TMO        = 300;
    localparam int NCH        = 6;
    localparam int RW         = 14;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           conv = 1'b0;
    logic           sck = 1'b0;
    logic [2:0]     chan_cnt = 3'd6;
    logic [NCH*RW-1:0] sample = '0;
    logic           sdo, busy, tviol;

    int n_checks = 0;
    int n_fail   = 0;

    logic [RW-1:0] res_m  [NCH];
    logic [RW-1:0] pend_m [NCH];
    logic [RW-1:0] drv    [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    sadc_frame_top #(.TIMEOUT_CYC(TMO)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_i     (conv),
        .sck_i      (sck),
        .chan_cnt_i (chan_cnt),
        .sample_i   (sample),
        .sdo_o      (sdo),
        .busy_o     (busy),
        .tviol_o    (tviol)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_conv();
        conv = 1'b1;
        tick(4);
        conv = 1'b0;
    endtask

    task automatic sck_cycle();
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
        tick(HALF);
    endtask

    function automatic logic exp_bit(input int k);
        int slot = k / 16;
        int pos  = k % 16;
        return (pos < RW) ? res_m[slot][RW-1-pos] : 1'b0;
    endfunction

    // Full frame: conversion, scramble inputs, read 96 bits, compare with model.
    task automatic frame(input int n, input string req, input int pre_wait,
                         input int stall_at, input bit mid_conv);
        int eff;
        int bad_k;
        int bad_act;
        eff = (n == 0 || n > NCH) ? NCH : n;
        for (int c = 0; c < NCH; c++) sample[c*RW +: RW] = drv[c];
        chan_cnt = 3'(n);
        pulse_conv();
        tick(2);
        check("R3", "busy after accept", int'(busy), 1);
        for (int c = 0; c < eff; c++) pend_m[c] = drv[c];
        sample = ~sample;          // R1: later input changes must not matter
        if (pre_wait > 0) begin
            tick(pre_wait);
            check("R7", "late first clock flag", int'(tviol), 1);
        end else begin
            check("R8", "flag cleared by accept", int'(tviol), 0);
        end
        tick(HALF);
        bad_k = -1;
        bad_act = 0;
        for (int k = 0; k < 96; k++) begin
            if (sdo !== exp_bit(k) && bad_k < 0) begin
                bad_k = k;
                bad_act = int'(sdo);
            end
            if (k == stall_at) begin
                tick(TMO + 100);
                check("R8", "clock gap flag", int'(tviol), 1);
            end
            if (mid_conv && k == 40) begin
                for (int c = 0; c < NCH; c++) sample[c*RW +: RW] = 14'h2AAA ^ 14'(c);
                pulse_conv();
                tick(4);
                check("R2", "busy held through ignored edge", int'(busy), 1);
            end
            if (k == 95) begin
                sck = 1'b1;
                tick(2);
                check("R3", "busy before last rise seen", int'(busy), 1);
                tick(HALF - 2);
                sck = 1'b0;
                tick(HALF);
            end else begin
                sck_cycle();
            end
        end
        check(req, $sformatf("frame data first bad bit %0d", bad_k), bad_act,
              (bad_k < 0) ? 0 : int'(exp_bit(bad_k)));
        check("R3", "busy after frame", int'(busy), 0);
        check("R4", "sdo idle after frame", int'(sdo), 0);
        if (pre_wait == 0 && stall_at < 0)
            check("R7", "no flag on clean frame", int'(tviol), 0);
        for (int c = 0; c < NCH; c++) res_m[c] = pend_m[c];
        tick(10);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        check("R9", "busy after reset", int'(busy), 0);
        check("R9", "sdo after reset", int'(sdo), 0);
        check("R9", "tviol after reset", int'(tviol), 0);
        for (int c = 0; c < NCH; c++) begin
            res_m[c]  = '0;
            pend_m[c] = '0;
        end
    endtask

    task automatic t_first_frame();
        for (int c = 0; c < NCH; c++) drv[c] = 14'h1000 + 14'(c * 14'h0123);
        frame(6, "R9", 0, -1, 1'b0);       // reads zero results
    endtask

    task automatic t_second_frame();
        for (int c = 0; c < NCH; c++) drv[c] = 14'h3F00 ^ 14'(c * 14'h0511);
        frame(6, "R5", 0, -1, 1'b0);       // reads first conversion, R4 slot order
    endtask

    task automatic t_partial();
        for (int c = 0; c < NCH; c++) drv[c] = 14'h0A5A + 14'(c * 14'h0101);
        frame(3, "R4", 0, -1, 1'b0);
        for (int c = 0; c < NCH; c++) drv[c] = 14'h2222 + 14'(c);
        frame(0, "R6", 0, -1, 1'b0);       // channels 3..5 stale; count 0 means all
        for (int c = 0; c < NCH; c++) drv[c] = 14'h1357 ^ 14'(c << 4);
        frame(6, "R1", 0, -1, 1'b0);
    endtask

    task automatic t_lockout();
        for (int c = 0; c < NCH; c++) drv[c] = 14'h0F0F + 14'(c * 3);
        frame(6, "R2", 0, -1, 1'b1);
        for (int c = 0; c < NCH; c++) drv[c] = 14'h3001 + 14'(c);
        frame(6, "R2", 0, -1, 1'b0);       // data must be the accepted capture
    endtask

    task automatic t_timing();
        for (int c = 0; c < NCH; c++) drv[c] = 14'h1111 * 14'(c + 1);
        frame(6, "R7", TMO + 100, -1, 1'b0);
        for (int c = 0; c < NCH; c++) drv[c] = 14'h0777 + 14'(c);
        frame(6, "R8", 0, 50, 1'b0);
        frame(6, "R5", 0, -1, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_first_frame();
        t_second_frame();
        t_partial();
        t_lockout();
        t_timing();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule